// File: doc/BRIEF.md
# NAND Hamming ECC accumulator

This block sits beside the byte-wide data path of a NAND flash controller and builds a single-error-correcting Hamming code over the bytes that flow through it. Each 256-byte chunk produces one 3-byte code. The code has sixteen line-parity bits taken over the byte index and six column-parity bits taken over the bit position inside each byte. A page of 256 bytes gives one code. A page of 512 bytes gives two codes, and the block moves on to the second chunk by itself.

Software controls the block through a 2-bit field of the controller's mode register. The usual sequence is clear, then idle, then accumulate, then the page transfer. To fetch the result, software selects read-out and reads the data register repeatedly. In read-out mode the data register returns the stored code bytes in a fixed order instead of flash data. Software compares the stored code with the one it read from the spare area and performs any correction itself.

Top module: `nand_ecc_acc`

## Requirements
- R1: A write with `ctrlWr` high loads the mode from `ctrlWrData[6:5]`: 2'b11 is clear, 2'b01 is accumulate, 2'b10 is read-out and 2'b00 is idle. The other bits of `ctrlWrData` have no effect.
- R2: Each clock edge in clear mode zeroes the parity accumulators, the byte position and the chunk index, and sets every stored code byte to 0xFF.
- R3: Only in accumulate mode does a byte with `dataValid` high change the accumulators. Bytes presented in idle, clear or read-out mode are ignored, and accumulation resumes unchanged after a return to accumulate without a clear.
- R4: For byte index i (0..255) with row parity r = XOR of its bits, line bit LP(2k) collects r where bit k of i is 0, and LP(2k+1) collects r where bit k of i is 1. Column bit CP(2j) is the XOR of all data bits whose position has bit j equal to 0, and CP(2j+1) is the XOR of those whose position has bit j equal to 1. The code bytes are: high = ~LP[15:8], low = ~LP[7:0], column = {~CP[5:0], 2'b11}.
- R5: After the 256th accepted byte of a chunk, the block latches that chunk's code into the next slot and restarts the accumulators for the following chunk with no software action.
- R6: Once two codes (NUM_CODES) are stored, further bytes are ignored until the next clear.
- R7: In read-out mode, `rdData` returns the high, low and column bytes of code 0, then those of code 1. Each `rdStrobe` advances one byte. After the last byte the sequence wraps to the first. Every entry into read-out mode restarts it at the first byte.
- R8: Outside read-out mode, `rdData` equals `flashByte`.
- R9: After reset the mode is idle and every stored code byte reads 0xFF.
- R10: A chunk of 256 bytes of 0xFF produces the code 0xFF, 0xFF, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Write strobe for the mode register |
| ctrlWrData | input | 8 | Mode register write data; bits [6:5] hold the mode |
| dataValid | input | 1 | A byte passes through the flash data path this cycle |
| dataByte | input | 8 | The byte on the data path |
| rdStrobe | input | 1 | Read of the data register this cycle |
| flashByte | input | 8 | Flash read data, passed through outside read-out mode |
| rdData | output | 8 | Data register read value |

## Verification
The bench runs random two-chunk pages through a reference model, with random idle gaps between bytes. A mismatch here points to wrong index or bit-position weighting, or to a wrong chunk boundary. A directed chunk with a single set bit at byte 0 has a code derived by hand, so it tells apart an error in the model from an error in the bit ordering of the code bytes. An all-0xFF page checks the inversion. Junk bytes sent in idle and read-out mode, extra bytes after both slots are full, repeated reads past the sixth byte and re-entry into read-out mode separate the gating, saturation, wrap and pointer-restart behaviour from the parity arithmetic.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int BYTE_W      = 8;
  localparam int CHUNK_BYTES = 256;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int LINE_W      = 2 * IDX_W;
  localparam int COL_W       = 2 * $clog2(BYTE_W);
  localparam int CODE_BYTES  = 3;
  localparam int CODE_W      = CODE_BYTES * BYTE_W;
  localparam int SLOT_W      = 4;
  localparam int MODE_LSB    = 5;

  localparam logic [1:0] RD_HI  = 2'd0;
  localparam logic [1:0] RD_LO  = 2'd1;
  localparam logic [1:0] RD_COL = 2'd2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_ACC   = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } eccMode_e;

  typedef struct packed {
    logic              clrAll;
    logic              accEn;
    logic              latchCode;
    logic [IDX_W-1:0]  byteIdx;
    logic [SLOT_W-1:0] slotIdx;
    logic              rdSel;
    logic [SLOT_W-1:0] rdCode;
    logic [1:0]        rdByte;
  } eccStrobe_t;

  // Mask of bit positions whose index bit j equals hi.
  function automatic logic [BYTE_W-1:0] colMask(input int j, input logic hi);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) begin
      m[b] = (((b >> j) & 1) == 1) == hi;
    end
    return m;
  endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CODES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWr,
  input  logic [BYTE_W-1:0] ctrlWrData,
  input  logic              dataValid,
  input  logic              rdStrobe,
  output eccStrobe_t        strb
);

  localparam logic [SLOT_W-1:0] SLOT_FULL = SLOT_W'(NUM_CODES);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_CODES - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(CHUNK_BYTES - 1);

  eccMode_e          mode;
  logic [IDX_W-1:0]  byteCnt;
  logic [SLOT_W-1:0] chunkIdx;
  logic [SLOT_W-1:0] rdCode;
  logic [1:0]        rdByte;
  logic              slotsFull;
  logic              accept;
  logic              chunkDone;

  assign slotsFull = (chunkIdx >= SLOT_FULL);
  assign accept    = (mode == MODE_ACC) && dataValid && !slotsFull;
  assign chunkDone = accept && (byteCnt == IDX_LAST);

  // Mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_IDLE;
    end else if (ctrlWr) begin
      mode <= eccMode_e'(ctrlWrData[MODE_LSB+1:MODE_LSB]);
    end
  end

  // Byte position and chunk slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt  <= '0;
      chunkIdx <= '0;
    end else if (mode == MODE_CLEAR) begin
      byteCnt  <= '0;
      chunkIdx <= '0;
    end else if (accept) begin
      byteCnt <= byteCnt + 1'b1;
      if (chunkDone) begin
        chunkIdx <= chunkIdx + 1'b1;
      end
    end
  end

  // Read-out pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdCode <= '0;
      rdByte <= RD_HI;
    end else if (mode != MODE_READ) begin
      rdCode <= '0;
      rdByte <= RD_HI;
    end else if (rdStrobe) begin
      if (rdByte == RD_COL) begin
        rdByte <= RD_HI;
        rdCode <= (rdCode == SLOT_LAST) ? '0 : rdCode + 1'b1;
      end else begin
        rdByte <= rdByte + 1'b1;
      end
    end
  end

  always_comb begin
    strb.clrAll    = (mode == MODE_CLEAR);
    strb.accEn     = accept;
    strb.latchCode = chunkDone;
    strb.byteIdx   = byteCnt;
    strb.slotIdx   = chunkIdx;
    strb.rdSel     = (mode == MODE_READ);
    strb.rdCode    = rdCode;
    strb.rdByte    = rdByte;
  end

  a_r1_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> mode == eccMode_e'($past(ctrlWrData[MODE_LSB+1:MODE_LSB])));

  a_r2_clear_position: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> (byteCnt == '0) && (chunkIdx == '0));

  a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    chunkIdx <= SLOT_FULL);

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slotsFull && (mode != MODE_CLEAR) |=> $stable(byteCnt) && $stable(chunkIdx));

  a_r7_ptr_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == MODE_READ) |-> (rdByte == RD_HI) && (rdCode == '0));

  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rdByte != 2'd3) && (rdCode <= SLOT_LAST));

endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CODES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eccStrobe_t        strb,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic [BYTE_W-1:0] flashByte,
  output logic [BYTE_W-1:0] rdData
);

  logic [LINE_W-1:0] lineAcc, lineNext;
  logic [COL_W-1:0]  colAcc, colNext;
  logic              rowPar;
  logic [CODE_W-1:0] codeNew;
  logic [CODE_W-1:0] codeStore [NUM_CODES];
  logic [CODE_W-1:0] codeSel;

  assign rowPar = ^dataByte;

  // Line parity: each index bit steers the row parity into one of two bits
  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lineNext[2*k]   = lineAcc[2*k]   ^ (rowPar & ~strb.byteIdx[k]);
    assign lineNext[2*k+1] = lineAcc[2*k+1] ^ (rowPar &  strb.byteIdx[k]);
  end

  // Column parity: each bit-position bit splits the byte into two halves
  for (genvar j = 0; j < COL_W / 2; j++) begin : g_col
    localparam logic [BYTE_W-1:0] MASK_LO = colMask(j, 1'b0);
    localparam logic [BYTE_W-1:0] MASK_HI = colMask(j, 1'b1);
    assign colNext[2*j]   = colAcc[2*j]   ^ (^(dataByte & MASK_LO));
    assign colNext[2*j+1] = colAcc[2*j+1] ^ (^(dataByte & MASK_HI));
  end

  assign codeNew = {~lineNext[15:8], ~lineNext[7:0], ~colNext, 2'b11};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (strb.clrAll) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (strb.accEn) begin
      if (strb.latchCode) begin
        lineAcc <= '0;
        colAcc  <= '0;
      end else begin
        lineAcc <= lineNext;
        colAcc  <= colNext;
      end
    end
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codeStore[g] <= '1;
      end else if (strb.clrAll) begin
        codeStore[g] <= '1;
      end else if (strb.latchCode && (strb.slotIdx == SLOT_W'(g))) begin
        codeStore[g] <= codeNew;
      end
    end

    a_r2_clear_store: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clrAll |=> (codeStore[g] == '1));
  end

  always_comb begin
    codeSel = '1;
    for (int g = 0; g < NUM_CODES; g++) begin
      if (strb.rdCode == SLOT_W'(g)) codeSel = codeStore[g];
    end
  end

  always_comb begin
    if (!strb.rdSel) begin
      rdData = flashByte;
    end else begin
      case (strb.rdByte)
        RD_HI:   rdData = codeSel[23:16];
        RD_LO:   rdData = codeSel[15:8];
        default: rdData = codeSel[7:0];
      endcase
    end
  end

  a_r3_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.accEn && !strb.clrAll |=> $stable(lineAcc) && $stable(colAcc));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchCode && !strb.clrAll |=> (lineAcc == '0) && (colAcc == '0));

  a_r4_col_fill: assert property (@(posedge clk) disable iff (!rst_n)
    codeStore[0][1:0] == 2'b11);

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CODES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlWrData,
  input  logic       dataValid,
  input  logic [7:0] dataByte,
  input  logic       rdStrobe,
  input  logic [7:0] flashByte,
  output logic [7:0] rdData
);

  eccStrobe_t strb;

  nand_ecc_ctrl #(.NUM_CODES(NUM_CODES)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (ctrlWrData),
    .dataValid  (dataValid),
    .rdStrobe   (rdStrobe),
    .strb       (strb)
  );

  nand_ecc_datapath #(.NUM_CODES(NUM_CODES)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .dataByte  (dataByte),
    .flashByte (flashByte),
    .rdData    (rdData)
  );

endmodule

// File: tb/test_nand_ecc_acc.sv
module test_nand_ecc_acc;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam logic [1:0] M_IDLE  = 2'b00;
  localparam logic [1:0] M_ACC   = 2'b01;
  localparam logic [1:0] M_READ  = 2'b10;
  localparam logic [1:0] M_CLEAR = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic       dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] flashByte = '0;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] chunkA [256];
  logic [7:0] chunkB [256];
  logic [23:0] codeA, codeB;
  logic [7:0] got;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_ecc_acc i_nand_ecc_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (ctrlWrData),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .rdStrobe   (rdStrobe),
    .flashByte  (flashByte),
    .rdData     (rdData)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Reference code over one 256-byte chunk: {high, low, column}
  function automatic logic [23:0] refCode(input logic [7:0] c [256]);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      logic r = ^c[i];
      for (int k = 0; k < 8; k++) begin
        if (((i >> k) & 1) == 1) lp[2*k+1] ^= r;
        else                     lp[2*k]   ^= r;
      end
      for (int b = 0; b < 8; b++) begin
        if (c[i][b]) begin
          for (int j = 0; j < 3; j++) begin
            if (((b >> j) & 1) == 1) cp[2*j+1] ^= 1'b1;
            else                     cp[2*j]   ^= 1'b1;
          end
        end
      end
    end
    return {~lp[15:8], ~lp[7:0], ~cp, 2'b11};
  endfunction

  // Other register bits are random: only [6:5] may matter (R1)
  task automatic setMode(input logic [1:0] m);
    logic [7:0] junk = 8'($urandom);
    @(negedge clk);
    ctrlWr = 1'b1;
    ctrlWrData = {junk[7], m, junk[4:0]};
    @(posedge clk);
    #1 ctrlWr = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    if (($urandom % 4) == 0) @(negedge clk);
    @(negedge clk);
    dataValid = 1'b1;
    dataByte = b;
    @(posedge clk);
    #1 dataValid = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk);
    rdStrobe = 1'b1;
    #1 v = rdData;
    @(posedge clk);
    #1 rdStrobe = 1'b0;
  endtask

  task automatic readCode(input logic [23:0] exp, input string req);
    for (int n = 0; n < 3; n++) begin
      logic [7:0] e = exp[23 - 8*n -: 8];
      readByte(got);
      check(got == e, req, got, e);
    end
  endtask

  task automatic armAcc();
    setMode(M_CLEAR);
    setMode(M_IDLE);
    setMode(M_ACC);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    flashByte = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state, passthrough and all-0xFF store
    @(negedge clk);
    check(rdData == 8'h5A, "R9 reset passthrough", rdData, 8'h5A);
    setMode(M_READ);
    readCode(24'hFFFFFF, "R9 reset code0");
    readCode(24'hFFFFFF, "R9 reset code1");

    // R8: passthrough in accumulate mode
    setMode(M_ACC);
    flashByte = 8'hC3;
    @(negedge clk);
    check(rdData == 8'hC3, "R8 passthrough accumulate", rdData, 8'hC3);

    // R4 directed: single bit 0 set at byte 0 gives AA AA AB
    for (int i = 0; i < 256; i++) chunkA[i] = 8'h00;
    chunkA[0] = 8'h01;
    for (int i = 0; i < 256; i++) chunkB[i] = 8'($urandom);
    codeB = refCode(chunkB);
    armAcc();
    for (int i = 0; i < 256; i++) sendByte(chunkA[i]);
    for (int i = 0; i < 256; i++) sendByte(chunkB[i]);
    setMode(M_READ);
    readCode(24'hAAAAAB, "R4 directed single bit");
    readCode(codeB, "R5 second chunk");

    // R4 R5 R7: random page, wrap and restart
    for (int i = 0; i < 256; i++) chunkA[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) chunkB[i] = 8'($urandom);
    codeA = refCode(chunkA);
    codeB = refCode(chunkB);
    armAcc();
    for (int i = 0; i < 256; i++) sendByte(chunkA[i]);
    for (int i = 0; i < 256; i++) sendByte(chunkB[i]);
    setMode(M_READ);
    readCode(codeA, "R4 random code0");
    readCode(codeB, "R5 random code1");
    readCode(codeA, "R7 wrap to code0");
    readByte(got);
    check(got == codeB[23:16], "R7 wrap continues", got, codeB[23:16]);
    setMode(M_IDLE);
    setMode(M_READ);
    readByte(got);
    check(got == codeA[23:16], "R7 restart on entry", got, codeA[23:16]);

    // R6: extra bytes after both slots full are ignored
    setMode(M_ACC);
    for (int i = 0; i < 40; i++) sendByte(8'($urandom));
    setMode(M_READ);
    readCode(codeA, "R6 full code0");
    readCode(codeB, "R6 full code1");

    // R3 R10: junk in idle and read-out, then erased chunk
    for (int i = 0; i < 256; i++) chunkA[i] = 8'($urandom);
    codeA = refCode(chunkA);
    armAcc();
    for (int i = 0; i < 100; i++) sendByte(chunkA[i]);
    setMode(M_IDLE);
    for (int i = 0; i < 30; i++) sendByte(8'($urandom));
    setMode(M_READ);
    for (int i = 0; i < 20; i++) sendByte(8'($urandom));
    setMode(M_ACC);
    for (int i = 100; i < 256; i++) sendByte(chunkA[i]);
    for (int i = 0; i < 256; i++) sendByte(8'hFF);
    setMode(M_READ);
    readCode(codeA, "R3 ignored bytes");
    readCode(24'hFFFFFF, "R10 erased chunk");

    // R2: clear restores all-0xFF codes, then a fresh page works
    setMode(M_CLEAR);
    setMode(M_READ);
    readCode(24'hFFFFFF, "R2 clear code0");
    readCode(24'hFFFFFF, "R2 clear code1");
    for (int i = 0; i < 256; i++) chunkA[i] = 8'($urandom);
    codeA = refCode(chunkA);
    setMode(M_IDLE);
    setMode(M_ACC);
    for (int i = 0; i < 256; i++) sendByte(chunkA[i]);
    setMode(M_READ);
    readCode(codeA, "R2 after clear code0");
    readCode(24'hFFFFFF, "R2 after clear code1");

    report();
  end

endmodule